// File: doc/BRIEF.md
# Ethernet DMA Status and Interrupt Register Block

This block holds the software-visible control and status state for the DMA engine of an Ethernet MAC. A processor reaches it through a small word-addressed bus. Combinational read data is returned for the selected word. A write lands on the clock edge where the write strobe is high. For each direction the block holds an enable bit, a descriptor pointer and a status word. It also holds a set of MAC configuration words with fixed reset values, an interrupt mask, and a read-only word of pending interrupts.

The transmit and receive datapaths report events as single-cycle pulses. A completed frame is counted, and it raises a sticky completion flag. An underrun or overflow error raises a sticky error flag and turns off the enable of its own direction, so that the datapath stops. Software acknowledges a completion by writing 1 to the flag bit, which takes one frame off the count. It acknowledges an error by writing 1 to the error bit. One level interrupt output follows the OR of the masked status, one cycle behind.

Top module: `ethdma_regs`

## Requirements
- R1: After reset the configuration words read 0x80000000 (address 0), 0x00007000 (address 1), 0x40605060 (address 2), 0x00A1F037 (address 3) and 0x00000600 (address 4). Every other word reads 0 and irq_o is low. Configuration words read back the value last written to them.
- R2: A tx_done_i pulse adds one to the transmit frame count and sets the sent flag. The transmit status word is at address 7: bit 0 is the sent flag, bit 1 is underrun, and bits 23:16 hold the count. All other bits read 0.
- R3: A tx_underrun_i pulse sets bit 1 of the transmit status word and clears the transmit enable (bit 0 at address 5) from the next cycle on.
- R4: A rx_overflow_i pulse sets bit 2 of the receive status word and clears the receive enable (bit 0 at address 8) from the next cycle on. The receive status word is at address 10: bit 0 is the received flag, bit 2 is overflow, and bits 23:16 hold the count.
- R5: Writing 1 to an error bit clears it. Writing 0 to it leaves it set.
- R6: Writing 1 to bit 0 of a status word takes one off that direction's count. The flag clears when the count reaches zero. A count of zero stays at zero.
- R7: A rx_done_i pulse adds one to the receive frame count and sets the received flag.
- R8: Writes to the descriptor pointers (transmit at address 6, receive at address 9) store the value with bits 1:0 forced to zero.
- R9: The pending word (address 12, read-only) equals the mask (address 11, bits 7:0) ANDed with {receive status[3:0], transmit status[3:0]}.
- R10: irq_o equals the OR of the pending word as it stood one clock earlier.
- R11: Only bit 0 of the control words (addresses 5 and 8) is stored. tx_dma_en_o and rx_dma_en_o present these bits.
- R12: When an event and its acknowledge write arrive in the same cycle, the event wins. A done pulse together with an ack leaves a nonzero count unchanged. An error pulse beats a clearing write to the error bit. It also beats a write that sets the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 4 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected word |
| tx_done_i | input | 1 | Transmit frame completed (pulse) |
| tx_underrun_i | input | 1 | Transmit underrun (pulse) |
| rx_done_i | input | 1 | Receive frame completed (pulse) |
| rx_overflow_i | input | 1 | Receive overflow (pulse) |
| tx_dma_en_o | output | 1 | Transmit DMA enable |
| rx_dma_en_o | output | 1 | Receive DMA enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The status logic is driven with several patterns. A pair of completion pulses followed by acknowledges checks that the count is kept separately from the flag, and that the flag stays set until the count drains. A further acknowledge at zero shows that the count does not wrap. Error pulses are sent with the mask open and with the mask closed. This separates the raw status from the pending word, and comparing irq_o one cycle apart shows the register stage. Events that collide with their own acknowledge or enable write show which side has priority. The receive errors sit at a different bit than the transmit errors, which checks that each half of the interrupt vector comes from its own channel.

// File: rtl/ethdma_pkg.sv
// Shared constants for the Ethernet DMA register block: bus width,
// word addresses and the configuration reset values.
// Assumes a word-addressed bus with one 32-bit word per address.
package ethdma_pkg;
    localparam int DATA_W   = 32;
    localparam int ADR_W    = 4;
    localparam int NUM_CFG  = 5;
    localparam int NUM_CHAN = 2;
    localparam int CNT_W    = 8;
    localparam int CNT_LSB  = 16;
    localparam int NIB_W    = 4;
    localparam int MASK_W   = NUM_CHAN * NIB_W;

    localparam int ADR_CHAN_BASE = 5;
    localparam int CHAN_STRIDE   = 3;
    localparam int ADR_MASK      = 11;
    localparam int ADR_PEND      = 12;

    // Reset value of configuration word i.
    function automatic logic [DATA_W-1:0] cfg_reset(input int i);
        case (i)
            0:       return 32'h8000_0000;
            1:       return 32'h0000_7000;
            2:       return 32'h4060_5060;
            3:       return 32'h00A1_F037;
            4:       return 32'h0000_0600;
            default: return '0;
        endcase
    endfunction

    // Bit position of the error flag in channel c's status word.
    function automatic int err_bit(input int c);
        return (c == 0) ? 1 : 2;
    endfunction
endpackage

// File: rtl/ethdma_cfgreg.sv
// One plain read/write configuration word with a parameterised reset value.
// Assumes the write enable has already been decoded from the address.
module ethdma_cfgreg #(
    parameter int              DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Hold the word; load on write; return to the reset value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RST_VAL;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/ethdma_chan.sv
// Control, descriptor pointer and status state for one DMA direction.
// It counts completed frames and keeps sticky done and error flags. An
// error pulse turns the enable off. Events take priority over software
// writes in the same cycle. Assumes event inputs are single-cycle pulses.
module ethdma_chan #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 8,
    parameter int CNT_LSB = 16,
    parameter int ERR_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_desc,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_i,
    input  logic              err_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic [DATA_W-1:0] desc_o,
    output logic [DATA_W-1:0] stat_o,
    output logic              en_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              en_q, flag_q, err_q;
    logic [DATA_W-1:0] desc_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic              ack, err_clr, flag_nx, err_nx;

    assign ack     = wr_stat & wdata[0];
    assign err_clr = wr_stat & wdata[ERR_BIT];

    // Next count: the ack is floored at zero first, then the event adds one (saturating).
    always_comb begin
        unique case ({done_i, ack})
            2'b10:   cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            2'b01:   cnt_nx = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
            2'b11:   cnt_nx = (cnt_q == '0) ? CNT_W'(1) : cnt_q;
            default: cnt_nx = cnt_q;
        endcase
    end

    assign flag_nx = done_i | (flag_q & ~(ack & (cnt_nx == '0)));
    assign err_nx  = err_i | (err_q & ~err_clr);

    // Status state: frame count and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            flag_q <= flag_nx;
            err_q  <= err_nx;
        end
    end

    // Enable bit: an error turns it off, ahead of any software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (err_i)   en_q <= 1'b0;
        else if (wr_ctl)  en_q <= wdata[0];
    end

    // Descriptor pointer, kept word aligned.
    always_ff @(posedge clk) begin
        if (!rst_n)       desc_q <= '0;
        else if (wr_desc) desc_q <= {wdata[DATA_W-1:2], 2'b00};
    end

    // Assemble the readable status word.
    always_comb begin
        stat_o                   = '0;
        stat_o[0]                = flag_q;
        stat_o[ERR_BIT]          = err_q;
        stat_o[CNT_LSB +: CNT_W] = cnt_q;
    end

    assign ctl_o  = {{(DATA_W-1){1'b0}}, en_q};
    assign desc_o = desc_q;
    assign en_o   = en_q;
endmodule

// File: rtl/ethdma_irq.sv
// Builds the masked pending vector from the per-channel status nibbles and
// registers the OR of that vector as the interrupt line.
// Assumes channel 0 takes the low nibble of the vector.
module ethdma_irq #(
    parameter int NUM_CHAN = 2,
    parameter int NIB_W    = 4,
    localparam int VEC_W   = NUM_CHAN * NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] nib_i,
    input  logic [VEC_W-1:0] mask_i,
    output logic [VEC_W-1:0] pend_o,
    output logic             irq_o
);
    assign pend_o = nib_i & mask_i;

    // Register the interrupt level one cycle behind the pending vector.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |pend_o;
    end
endmodule

// File: rtl/ethdma_regs.sv
// Top of the Ethernet DMA register block. It decodes the word bus, holds the
// configuration words and the interrupt mask, places one channel block per
// direction, and returns read data for the selected word.
// Assumes a single-cycle write strobe and combinational reads.
module ethdma_regs
    import ethdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADR_W-1:0]  bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tx_done_i,
    input  logic              tx_underrun_i,
    input  logic              rx_done_i,
    input  logic              rx_overflow_i,
    output logic              tx_dma_en_o,
    output logic              rx_dma_en_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] cfg_q  [NUM_CFG];
    logic [DATA_W-1:0] ctl_w  [NUM_CHAN];
    logic [DATA_W-1:0] desc_w [NUM_CHAN];
    logic [DATA_W-1:0] stat_w [NUM_CHAN];
    logic [NUM_CHAN-1:0] en_w, done_w, err_w;
    logic [MASK_W-1:0] mask_q, nib_w, pend_w;
    logic [DATA_W-1:0] tx_stat_w, rx_stat_w;

    assign done_w = {rx_done_i, tx_done_i};
    assign err_w  = {rx_overflow_i, tx_underrun_i};

    // Configuration words, one instance per word.
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        ethdma_cfgreg #(.DATA_W(DATA_W), .RST_VAL(cfg_reset(g))) u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr_i && (bus_sel_i == ADR_W'(g))),
            .wdata (bus_wdata_i),
            .q     (cfg_q[g])
        );
    end

    // One channel per direction: 0 is transmit, 1 is receive.
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        localparam int BASE = ADR_CHAN_BASE + c * CHAN_STRIDE;
        ethdma_chan #(
            .DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB), .ERR_BIT(err_bit(c))
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (bus_wr_i && (bus_sel_i == ADR_W'(BASE))),
            .wr_desc (bus_wr_i && (bus_sel_i == ADR_W'(BASE + 1))),
            .wr_stat (bus_wr_i && (bus_sel_i == ADR_W'(BASE + 2))),
            .wdata   (bus_wdata_i),
            .done_i  (done_w[c]),
            .err_i   (err_w[c]),
            .ctl_o   (ctl_w[c]),
            .desc_o  (desc_w[c]),
            .stat_o  (stat_w[c]),
            .en_o    (en_w[c])
        );
        assign nib_w[c*NIB_W +: NIB_W] = stat_w[c][NIB_W-1:0];
    end

    // Interrupt mask word.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (bus_wr_i && (bus_sel_i == ADR_W'(ADR_MASK))) mask_q <= bus_wdata_i[MASK_W-1:0];
    end

    ethdma_irq #(.NUM_CHAN(NUM_CHAN), .NIB_W(NIB_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .nib_i  (nib_w),
        .mask_i (mask_q),
        .pend_o (pend_w),
        .irq_o  (irq_o)
    );

    // Read multiplexer; unmapped addresses read zero.
    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (bus_sel_i == ADR_W'(i)) bus_rdata_o = cfg_q[i];
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (bus_sel_i == ADR_W'(ADR_CHAN_BASE + c*CHAN_STRIDE))     bus_rdata_o = ctl_w[c];
            if (bus_sel_i == ADR_W'(ADR_CHAN_BASE + c*CHAN_STRIDE + 1)) bus_rdata_o = desc_w[c];
            if (bus_sel_i == ADR_W'(ADR_CHAN_BASE + c*CHAN_STRIDE + 2)) bus_rdata_o = stat_w[c];
        end
        if (bus_sel_i == ADR_W'(ADR_MASK)) bus_rdata_o = DATA_W'(mask_q);
        if (bus_sel_i == ADR_W'(ADR_PEND)) bus_rdata_o = DATA_W'(pend_w);
    end

    assign tx_dma_en_o = en_w[0];
    assign rx_dma_en_o = en_w[1];
    assign tx_stat_w   = stat_w[0];
    assign rx_stat_w   = stat_w[1];
endmodule

// File: rtl/ethdma_regs_chk.sv
// Checker for the DMA register block, attached to the top by bind.
// Watches the event pulses, the bus writes, the enables, the status words and the
// pending vector.
module ethdma_regs_chk
    import ethdma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADR_W-1:0]  bus_sel_i,
    input logic              bus_wr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              tx_done_i,
    input logic              tx_underrun_i,
    input logic              rx_done_i,
    input logic              rx_overflow_i,
    input logic              tx_dma_en_o,
    input logic              rx_dma_en_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] tx_stat_w,
    input logic [DATA_W-1:0] rx_stat_w,
    input logic [MASK_W-1:0] pend_w
);
    logic tx_stat_wr;
    assign tx_stat_wr = bus_wr_i && (bus_sel_i == ADR_W'(ADR_CHAN_BASE + 2));

    assert_sent_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> tx_stat_w[0]);

    assert_underrun_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun_i |=> (!tx_dma_en_o && tx_stat_w[1]));

    assert_overflow_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow_i |=> (!rx_dma_en_o && rx_stat_w[2]));

    assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stat_wr && bus_wdata_i[1] && !tx_underrun_i) |=> !tx_stat_w[1]);

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stat_wr && bus_wdata_i[0] && !tx_done_i && tx_stat_w[CNT_LSB +: CNT_W] == '0)
        |=> (tx_stat_w[CNT_LSB +: CNT_W] == '0 && !tx_stat_w[0]));

    assert_rcvd_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> rx_stat_w[0]);

    assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|pend_w)));
endmodule

bind ethdma_regs ethdma_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel_i     (bus_sel_i),
    .bus_wr_i      (bus_wr_i),
    .bus_wdata_i   (bus_wdata_i),
    .tx_done_i     (tx_done_i),
    .tx_underrun_i (tx_underrun_i),
    .rx_done_i     (rx_done_i),
    .rx_overflow_i (rx_overflow_i),
    .tx_dma_en_o   (tx_dma_en_o),
    .rx_dma_en_o   (rx_dma_en_o),
    .irq_o         (irq_o),
    .tx_stat_w     (tx_stat_w),
    .rx_stat_w     (rx_stat_w),
    .pend_w        (pend_w)
);

// File: tb/ethdma_regs_tb_top.sv
`timescale 1ns/1ps
module ethdma_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd = 1'b0, txu = 1'b0, rxd = 1'b0, rxo = 1'b0;
    logic        tx_en, rx_en, irq;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ethdma_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tx_done_i(txd), .tx_underrun_i(txu), .rx_done_i(rxd), .rx_overflow_i(rxo),
        .tx_dma_en_o(tx_en), .rx_dma_en_o(rx_en), .irq_o(irq)
    );

    // Table row: {is_read, address, write data, expected read data}
    localparam int NV = 19;
    localparam logic [68:0] VEC [NV] = '{
        {1'b1, 4'd0,  32'h0, 32'h8000_0000},   // R1
        {1'b1, 4'd1,  32'h0, 32'h0000_7000},   // R1
        {1'b1, 4'd2,  32'h0, 32'h4060_5060},   // R1
        {1'b1, 4'd3,  32'h0, 32'h00A1_F037},   // R1
        {1'b1, 4'd4,  32'h0, 32'h0000_0600},   // R1
        {1'b1, 4'd7,  32'h0, 32'h0},           // R1
        {1'b1, 4'd10, 32'h0, 32'h0},           // R1
        {1'b1, 4'd12, 32'h0, 32'h0},           // R9
        {1'b0, 4'd6,  32'h1234_567F, 32'h0},
        {1'b1, 4'd6,  32'h0, 32'h1234_567C},   // R8
        {1'b0, 4'd9,  32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd9,  32'h0, 32'hFFFF_FFFC},   // R8
        {1'b0, 4'd5,  32'hFFFF_FFFE, 32'h0},
        {1'b1, 4'd5,  32'h0, 32'h0},           // R11
        {1'b0, 4'd5,  32'h1, 32'h0},
        {1'b0, 4'd8,  32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd8,  32'h0, 32'h1},           // R11
        {1'b0, 4'd2,  32'hA5A5_A5A5, 32'h0},
        {1'b1, 4'd2,  32'h0, 32'hA5A5_A5A5}    // R1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Drive one cycle of bus write and event pulses; they are released just after the edge.
    task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d,
                        input logic e_txd, input logic e_txu, input logic e_rxd, input logic e_rxo);
        @(negedge clk);
        bus_sel = a; bus_wr = w; bus_wdata = d;
        txd = e_txd; txu = e_txu; rxd = e_rxd; rxo = e_rxo;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; txd = 1'b0; txu = 1'b0; rxd = 1'b0; rxo = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(a, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 enables after reset", {30'b0, tx_en, rx_en}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][68]) rd($sformatf("table row %0d", i), VEC[i][67:64], VEC[i][31:0]);
            else            wr(VEC[i][67:64], VEC[i][63:32]);
        end
        @(negedge clk);
        check("R11 enable outputs", {30'b0, tx_en, rx_en}, 32'h3);

        // R2 and R6: two frames, then three acknowledges
        step(4'd0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        step(4'd0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        rd("R2 count two", 4'd7, 32'h0002_0001);
        wr(4'd7, 32'h1);
        rd("R6 flag held at count one", 4'd7, 32'h0001_0001);
        wr(4'd7, 32'h1);
        rd("R6 flag clears at zero", 4'd7, 32'h0);
        wr(4'd7, 32'h1);
        rd("R6 no wrap below zero", 4'd7, 32'h0);

        // R3, R9, R10: underrun with mask fully open
        wr(4'd11, 32'hFF);
        step(4'd0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 tx enable cleared", {31'b0, tx_en}, 32'h0);
        check("R10 irq lags one cycle", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        rd("R3 underrun flag", 4'd7, 32'h0000_0002);
        rd("R9 pending tx error", 4'd12, 32'h0000_0002);

        // R5: writing 0 keeps the error, writing 1 clears it
        wr(4'd7, 32'h0);
        rd("R5 write zero ignored", 4'd7, 32'h0000_0002);
        wr(4'd7, 32'h2);
        rd("R5 write one clears", 4'd7, 32'h0);
        @(negedge clk);
        check("R10 irq drops", {31'b0, irq}, 32'h0);

        // R7 and R9: receive frame lands in the upper nibble
        step(4'd0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        rd("R7 rx count one", 4'd10, 32'h0001_0001);
        rd("R9 pending rx done", 4'd12, 32'h0000_0010);
        wr(4'd11, 32'h0F);
        rd("R9 masked off", 4'd12, 32'h0);
        @(negedge clk);
        check("R10 irq off after mask", {31'b0, irq}, 32'h0);

        // R4: overflow
        step(4'd0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R4 rx enable cleared", {31'b0, rx_en}, 32'h0);
        rd("R4 overflow flag", 4'd10, 32'h0001_0005);
        wr(4'd11, 32'h40);
        rd("R9 pending rx error", 4'd12, 32'h0000_0040);

        // R12: collisions between events and writes
        step(4'd10, 1'b1, 32'h1, 1'b0, 1'b0, 1'b1, 1'b0);
        rd("R12 done with ack keeps count", 4'd10, 32'h0001_0005);
        step(4'd10, 1'b1, 32'h4, 1'b0, 1'b0, 1'b0, 1'b1);
        rd("R12 overflow beats clear", 4'd10, 32'h0001_0005);
        wr(4'd10, 32'h4);
        rd("R5 rx error cleared", 4'd10, 32'h0001_0001);
        wr(4'd5, 32'h1);
        @(negedge clk);
        check("R11 tx enable set", {31'b0, tx_en}, 32'h1);
        step(4'd5, 1'b1, 32'h1, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R12 underrun beats enable write", {31'b0, tx_en}, 32'h0);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rd("R1 cfg word after reset", 4'd2, 32'h4060_5060);
        rd("R1 rx status after reset", 4'd10, 32'h0);
        check("R1 irq low after reset", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule